// File: doc/BRIEF.md
# Interrupt Source Coalescing State Controller

This block keeps a two-bit event state for each of `N` interrupt sources and decides, for every event, whether it is passed on to a downstream router or absorbed. Sources are either edge sources, where each cycle of a high `irq_in` bit is one event, or level sources, where `irq_in` is a line that stays high while the device wants service. Which sources are level is fixed by the `LEVEL_MASK` parameter. A forwarded event leaves the block as a notification carrying the source number.

Software reaches the state through a window of 8-byte big-endian accesses, one page per source or, in paired mode (`TWO_PAGE=1`), a pair of pages per source. The operation is encoded in the address. Depending on the offset, the window can trigger, signal end of service (EOI), read the state or force the state. In paired mode the lower page of each pair accepts triggers only. All operations are 256-byte granular, so the request port carries the byte address divided by 256 (`req_line`). One bit selects load or store, and store data carries no meaning. Every accepted request gets exactly one response word, and the state value sits in its low bits.

Both outgoing streams use valid/ready. A response or notification is held stable until it is taken. While either one is stalled, `req_ready` is low and no hardware event is serviced. The block executes at most one operation per cycle. A software request takes priority over pending hardware events, and among hardware events the lowest source number wins.

Top module: `pq_src_ctrl`

## Requirements
- R1: After reset every source is in state 01 (off), and `notify_valid`, `rsp_valid` and `err` are low.
- R2: A trigger moves 00 to 10 and forwards one notification. It moves 10 to 11 and leaves 11 and 01 unchanged, and none of these three forwards.
- R3: An EOI moves 10 to 00 with no notification and moves 11 to 10 with one notification. It leaves 00 and 01 unchanged. A load-EOI returns 1 when it forwarded and 0 otherwise.
- R4: The source number is `req_line` above the page bits. The offset nibble is `req_line[3:0]` (byte-offset bits 11:8). A load with offset nibble 8 to B returns the state without changing it.
- R5: Offset nibbles C to F force the state to nibble bits [1:0], for both loads and stores. A load of this kind returns the old state.
- R6: A store with offset nibble 0 to 3 is a trigger. A store with nibble 4 to 7 is an EOI only while `store_eoi_en` is 1, and otherwise it raises `err` and leaves the state unchanged. A store with nibble 8 to B raises `err` and has no effect.
- R7: With `TWO_PAGE=1`, `req_line[4]=0` selects the trigger page, where every store triggers. A load there raises `err`, returns all ones and changes nothing.
- R8: When a level source's line rises, the source is marked asserted. It forwards and moves to 10 only if its state was 00. When the line falls, the mark is cleared with no notification.
- R9: When an EOI completes on a level source that is still asserted and the EOI left state 00, the source moves to 10 and forwards, with a single notification in total.
- R10: Each cycle of a high `irq_in` on an edge source is captured and later applied as one trigger, even when that cycle is busy.
- R11: A notification carries the source number and is held with `notify_src` stable until `notify_ready`. Each operation produces at most one notification.
- R12: Every accepted request produces one response, held until `rsp_ready`. Stores respond with 0. A load of a source number at or beyond `N` responds with all ones and raises `err`, and `req_ready` is low while an output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_eoi_en | input | 1 | Enables EOI by store |
| irq_in | input | N | Edge pulses or level lines per source |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_line | input | LA_W | Byte address divided by 256 |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 64 | Response word |
| notify_valid | output | 1 | Forwarded event valid |
| notify_ready | input | 1 | Forwarded event taken |
| notify_src | output | IDX_W | Source number of forwarded event |
| err | output | 1 | One-cycle strobe for an invalid access |

## Verification
The bench checks the asymmetric transitions: a second trigger must coalesce into 11 without a notification, and an EOI from 11 must re-forward. A design that swapped or merged those states would either flood or lose events. An EOI on a still-asserted level source must re-forward exactly once. A design that skipped the re-run would lose the interrupt, and one that OR-ed the two paths carelessly would notify twice. The gated store-EOI, the undefined store range and the trigger page load are checked to leave the state unchanged, and a get follows each of them. Held notifications and responses under back-pressure are checked to stay stable and to block new requests.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

  typedef enum logic [1:0] {
    PQ_IDLE   = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_t;

  typedef enum logic [2:0] {
    OP_TRIG,
    OP_EOI,
    OP_GET,
    OP_SET,
    OP_BAD
  } op_t;

  typedef enum logic [1:0] {
    HW_EDGE,
    HW_RISE,
    HW_FALL
  } hw_t;

  typedef struct packed {
    pq_t  nxt;
    logic fwd;
  } step_t;

  function automatic step_t trig_step(pq_t s);
    step_t r;
    r.nxt = s;
    r.fwd = 1'b0;
    if (s == PQ_IDLE) begin
      r.nxt = PQ_PEND;
      r.fwd = 1'b1;
    end else if (s == PQ_PEND) begin
      r.nxt = PQ_QUEUED;
    end
    return r;
  endfunction

  function automatic step_t eoi_step(pq_t s);
    step_t r;
    r.nxt = s;
    r.fwd = 1'b0;
    if (s == PQ_PEND) begin
      r.nxt = PQ_IDLE;
    end else if (s == PQ_QUEUED) begin
      r.nxt = PQ_PEND;
      r.fwd = 1'b1;
    end
    return r;
  endfunction

  function automatic step_t level_step(pq_t s);
    step_t r;
    r.nxt = s;
    r.fwd = 1'b0;
    if (s == PQ_IDLE) begin
      r.nxt = PQ_PEND;
      r.fwd = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/pq_src_decode.sv
module pq_src_decode
  import pq_src_pkg::*;
#(
  parameter int N          = 12,
  parameter int IDX_W      = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int TWO_PAGE   = 1,
  parameter int LA_W       = 9
) (
  input  logic [LA_W-1:0]  line_addr,
  input  logic             is_store,
  input  logic             store_eoi_en,
  output op_t              op,
  output logic [IDX_W-1:0] idx,
  output pq_t              set_val
);

  localparam int SRC_LSB = PAGE_SHIFT - 8 + TWO_PAGE;

  logic [3:0] nib;
  logic       trig_pg;
  logic       in_range;

  assign nib      = line_addr[3:0];
  assign idx      = line_addr[LA_W-1:SRC_LSB];
  assign in_range = 32'(idx) < N;
  assign set_val  = pq_t'(nib[1:0]);

  generate
    if (TWO_PAGE != 0) begin : g_pair
      assign trig_pg = ~line_addr[PAGE_SHIFT-8];
    end else begin : g_single
      assign trig_pg = 1'b0;
    end
  endgenerate

  always_comb begin
    op = OP_BAD;
    if (!in_range) begin
      op = OP_BAD;
    end else if (trig_pg) begin
      op = is_store ? OP_TRIG : OP_BAD;
    end else if (is_store) begin
      case (nib[3:2])
        2'b00:   op = OP_TRIG;
        2'b01:   op = store_eoi_en ? OP_EOI : OP_BAD;
        2'b10:   op = OP_BAD;
        default: op = OP_SET;
      endcase
    end else if (!nib[3]) begin
      op = OP_EOI;
    end else begin
      op = nib[2] ? OP_SET : OP_GET;
    end
  end

endmodule

// File: rtl/pq_src_hwsel.sv
module pq_src_hwsel
  import pq_src_pkg::*;
#(
  parameter int           N          = 12,
  parameter int           IDX_W      = 4,
  parameter logic [N-1:0] LEVEL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_in,
  input  logic             take,
  output logic             hw_valid,
  output logic [IDX_W-1:0] hw_idx,
  output hw_t              hw_kind,
  output logic [N-1:0]     asserted
);

  logic [N-1:0] want;

  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      logic took;
      assign took = take && (hw_idx == IDX_W'(i));
      if (LEVEL_MASK[i]) begin : g_level
        logic lvl_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)    lvl_q <= 1'b0;
          else if (took) lvl_q <= irq_in[i];
        end
        assign want[i]     = irq_in[i] ^ lvl_q;
        assign asserted[i] = lvl_q;
      end else begin : g_edge
        logic pend_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pend_q <= 1'b0;
          else        pend_q <= (pend_q & ~took) | irq_in[i];
        end
        assign want[i]     = pend_q;
        assign asserted[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    hw_valid = 1'b0;
    hw_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want[i]) begin
        hw_valid = 1'b1;
        hw_idx   = IDX_W'(i);
      end
    end
    if (!LEVEL_MASK[hw_idx]) hw_kind = HW_EDGE;
    else if (irq_in[hw_idx]) hw_kind = HW_RISE;
    else                     hw_kind = HW_FALL;
  end

endmodule

// File: rtl/pq_src_ctrl.sv
module pq_src_ctrl
  import pq_src_pkg::*;
#(
  parameter int           N          = 12,
  parameter int           PAGE_SHIFT = 12,
  parameter int           TWO_PAGE   = 1,
  parameter logic [N-1:0] LEVEL_MASK = 12'hF00,
  localparam int          IDX_W      = $clog2(N),
  localparam int          LA_W       = PAGE_SHIFT - 8 + TWO_PAGE + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_eoi_en,
  input  logic [N-1:0]     irq_in,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_store,
  input  logic [LA_W-1:0]  req_line,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [63:0]      rsp_data,
  output logic             notify_valid,
  input  logic             notify_ready,
  output logic [IDX_W-1:0] notify_src,
  output logic             err
);

  op_t              dec_op;
  logic [IDX_W-1:0] dec_idx;
  pq_t              dec_set;
  logic             hw_valid;
  logic [IDX_W-1:0] hw_idx;
  hw_t              hw_kind;
  logic [N-1:0]     asserted;
  logic             stall, fire_req, fire_hw;
  logic [IDX_W-1:0] sel, sel_safe;
  pq_t              cur;
  step_t            step, lv;
  logic             wr, bad;
  logic [63:0]      rdata;
  pq_t              pq_q [N];

  pq_src_decode #(
    .N(N), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT),
    .TWO_PAGE(TWO_PAGE), .LA_W(LA_W)
  ) u_dec (
    .line_addr    (req_line),
    .is_store     (req_store),
    .store_eoi_en (store_eoi_en),
    .op           (dec_op),
    .idx          (dec_idx),
    .set_val      (dec_set)
  );

  pq_src_hwsel #(
    .N(N), .IDX_W(IDX_W), .LEVEL_MASK(LEVEL_MASK)
  ) u_hw (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .take     (fire_hw),
    .hw_valid (hw_valid),
    .hw_idx   (hw_idx),
    .hw_kind  (hw_kind),
    .asserted (asserted)
  );

  assign stall     = (notify_valid & ~notify_ready) | (rsp_valid & ~rsp_ready);
  assign req_ready = ~stall;
  assign fire_req  = req_valid & ~stall;
  assign fire_hw   = ~stall & ~req_valid & hw_valid;
  assign sel       = fire_req ? dec_idx : hw_idx;
  assign sel_safe  = (32'(sel) < N) ? sel : '0;
  assign cur       = pq_q[sel_safe];

  always_comb begin
    step.nxt = cur;
    step.fwd = 1'b0;
    lv       = step;
    wr       = 1'b0;
    bad      = 1'b0;
    rdata    = '0;
    if (fire_req) begin
      case (dec_op)
        OP_TRIG: begin
          step = trig_step(cur);
          wr   = 1'b1;
        end
        OP_EOI: begin
          step = eoi_step(cur);
          if (LEVEL_MASK[sel_safe] && asserted[sel_safe]) begin
            lv       = level_step(step.nxt);
            step.nxt = lv.nxt;
            step.fwd = step.fwd | lv.fwd;
          end
          wr = 1'b1;
          if (!req_store) rdata = {63'd0, step.fwd};
        end
        OP_GET: begin
          rdata = {62'd0, cur};
        end
        OP_SET: begin
          step.nxt = dec_set;
          wr       = 1'b1;
          if (!req_store) rdata = {62'd0, cur};
        end
        default: begin
          bad = 1'b1;
          if (!req_store) rdata = '1;
        end
      endcase
    end else if (fire_hw) begin
      case (hw_kind)
        HW_EDGE: begin
          step = trig_step(cur);
          wr   = 1'b1;
        end
        HW_RISE: begin
          step = level_step(cur);
          wr   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) pq_q[i] <= PQ_OFF;
    end else if (wr) begin
      pq_q[sel_safe] <= step.nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_valid <= 1'b0;
      notify_src   <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      err          <= 1'b0;
    end else begin
      if (notify_ready || !notify_valid) begin
        notify_valid <= (fire_req | fire_hw) & step.fwd;
        notify_src   <= sel_safe;
      end
      if (rsp_ready || !rsp_valid) begin
        rsp_valid <= fire_req;
        rsp_data  <= rdata;
      end
      err <= fire_req & bad;
    end
  end

endmodule

// File: rtl/pq_src_ctrl_chk.sv
module pq_src_ctrl_chk
  import pq_src_pkg::*;
#(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             notify_valid,
  input logic             notify_ready,
  input logic [IDX_W-1:0] notify_src,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [63:0]      rsp_data,
  input logic             err,
  input logic             fire_req,
  input logic             fire_hw,
  input logic             req_store,
  input op_t              dec_op,
  input hw_t              hw_kind
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !notify_valid && !rsp_valid && !err);

  assert_get_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_req && dec_op == OP_GET |=> rsp_valid && !notify_valid && !err);

  assert_err_no_notify_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !notify_valid);

  assert_bad_load_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_req && dec_op == OP_BAD && !req_store |=> err && rsp_valid && rsp_data == '1);

  assert_fall_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_hw && hw_kind == HW_FALL |=> !notify_valid);

  assert_notify_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid && !notify_ready |=> notify_valid && $stable(notify_src));

  assert_notify_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> 32'(notify_src) < N);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

endmodule

bind pq_src_ctrl pq_src_ctrl_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .notify_valid (notify_valid),
  .notify_ready (notify_ready),
  .notify_src   (notify_src),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .err          (err),
  .fire_req     (fire_req),
  .fire_hw      (fire_hw),
  .req_store    (req_store),
  .dec_op       (dec_op),
  .hw_kind      (hw_kind)
);

// File: tb/pq_src_ctrl_tb.sv
module pq_src_ctrl_tb;

  localparam int           N   = 12;
  localparam int           IW  = 4;
  localparam int           LW  = 12 - 8 + 1 + IW;
  localparam logic [N-1:0] LVL = 12'hF00;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          store_eoi_en = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_store = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [63:0]   rsp_data;
  logic          notify_valid;
  logic          notify_ready = 1'b1;
  logic [IW-1:0] notify_src;
  logic          err;

  pq_src_ctrl #(.N(N), .PAGE_SHIFT(12), .TWO_PAGE(1), .LEVEL_MASK(LVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .store_eoi_en(store_eoi_en), .irq_in(irq_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_line(req_line), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .notify_valid(notify_valid), .notify_ready(notify_ready),
    .notify_src(notify_src), .err(err)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [1:0] m_pq [N];
  bit         m_lvl [N];

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual %0d cycles expected under 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] f_trig(input logic [1:0] s);
    if (s == 2'b00) return 3'b110;
    if (s == 2'b10) return 3'b011;
    return {1'b0, s};
  endfunction

  function automatic logic [2:0] f_eoi(input logic [1:0] s);
    if (s == 2'b10) return 3'b000;
    if (s == 2'b11) return 3'b110;
    return {1'b0, s};
  endfunction

  function automatic logic [LW-1:0] la(input int src, input bit pg, input logic [3:0] off);
    return {IW'(src), pg, off};
  endfunction

  task automatic do_op(input bit st, input logic [LW-1:0] a, output logic [63:0] rd,
                       output bit nv, output logic [IW-1:0] ns, output bit er);
    @(negedge clk);
    req_valid = 1'b1;
    req_store = st;
    req_line  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    rd = rsp_data;
    nv = notify_valid;
    ns = notify_src;
    er = err;
  endtask

  task automatic mop(input bit st, input int src, input bit pg, input logic [3:0] off);
    logic [1:0] cur, nxt;
    logic [2:0] r;
    bit fwd, er, nv, ae;
    logic [63:0] exp_rd, rd;
    logic [IW-1:0] ns;
    string tag;
    cur = m_pq[src]; nxt = cur; fwd = 0; er = 0; exp_rd = '0; tag = "R2";
    r = 3'b000;
    if (!pg) begin
      if (st) begin r = f_trig(cur); nxt = r[1:0]; fwd = r[2]; tag = "R7 trig page"; end
      else begin er = 1; exp_rd = '1; tag = "R7 trig page load"; end
    end else if (st) begin
      case (off[3:2])
        2'b00: begin r = f_trig(cur); nxt = r[1:0]; fwd = r[2]; tag = "R2"; end
        2'b01: begin
          tag = "R6 store eoi";
          if (store_eoi_en) begin
            r = f_eoi(cur);
            if (LVL[src] && m_lvl[src] && r[1:0] == 2'b00) r = 3'b110;
            nxt = r[1:0]; fwd = r[2];
          end else er = 1;
        end
        2'b10: begin er = 1; tag = "R6 undefined store"; end
        default: begin nxt = off[1:0]; tag = "R5 set store"; end
      endcase
    end else if (!off[3]) begin
      r = f_eoi(cur);
      tag = "R3 load eoi";
      if (LVL[src] && m_lvl[src] && r[1:0] == 2'b00) begin r = 3'b110; tag = "R9 level eoi"; end
      nxt = r[1:0]; fwd = r[2]; exp_rd = {63'd0, fwd};
    end else if (!off[2]) begin
      exp_rd = {62'd0, cur}; tag = "R4 get";
    end else begin
      exp_rd = {62'd0, cur}; nxt = off[1:0]; tag = "R5 set load";
    end
    do_op(st, la(src, pg, off), rd, nv, ns, ae);
    chk(tag, rd, exp_rd);
    chk({tag, " err"}, {63'd0, ae}, {63'd0, er});
    chk("R11 notify", {63'd0, nv}, {63'd0, fwd});
    if (fwd) chk("R11 notify_src", {60'd0, ns}, 64'(src));
    m_pq[src] = nxt;
  endtask

  task automatic count_notify(input int cycles, output int cnt, output logic [IW-1:0] last);
    cnt = 0; last = '0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (notify_valid) begin cnt++; last = notify_src; end
    end
  endtask

  initial begin
    logic [63:0] rd;
    bit nv, er;
    logic [IW-1:0] ns;
    int cnt;
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin m_pq[i] = 2'b01; m_lvl[i] = 0; end

    repeat (3) @(negedge clk);
    chk("R1 notify in reset", {63'd0, notify_valid}, 64'd0);
    chk("R1 rsp in reset", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      do_op(1'b0, la(i, 1'b1, 4'h8), rd, nv, ns, er);
      chk("R1 reset state off", rd, 64'd1);
    end

    do_op(1'b0, la(13, 1'b1, 4'h8), rd, nv, ns, er);
    chk("R12 out of range load", rd, '1);
    chk("R12 out of range err", {63'd0, er}, 64'd1);

    mop(1'b1, 2, 1'b1, 4'hC);
    mop(1'b1, 2, 1'b0, 4'h0);
    mop(1'b1, 2, 1'b1, 4'h0);
    mop(1'b1, 2, 1'b1, 4'h1);
    mop(1'b0, 2, 1'b1, 4'h0);
    mop(1'b0, 2, 1'b1, 4'h4);
    mop(1'b0, 2, 1'b1, 4'h9);
    mop(1'b0, 2, 1'b0, 4'h8);
    mop(1'b0, 2, 1'b1, 4'hB);
    mop(1'b1, 2, 1'b1, 4'hA);
    mop(1'b0, 2, 1'b1, 4'h8);

    store_eoi_en = 1'b0;
    mop(1'b1, 1, 1'b1, 4'hE);
    mop(1'b1, 1, 1'b1, 4'h5);
    mop(1'b0, 1, 1'b1, 4'h8);
    store_eoi_en = 1'b1;
    mop(1'b1, 1, 1'b1, 4'h5);
    mop(1'b0, 1, 1'b1, 4'h8);

    // R10: captured edge pulse, applied once
    mop(1'b1, 3, 1'b1, 4'hC);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); irq_in[3] = 1'b0;
    count_notify(4, cnt, ns);
    chk("R10 edge forward count", 64'(cnt), 64'd1);
    chk("R10 edge notify_src", {60'd0, ns}, 64'd3);
    m_pq[3] = 2'b10;
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); irq_in[3] = 1'b0;
    count_notify(4, cnt, ns);
    chk("R10 coalesced edge", 64'(cnt), 64'd0);
    m_pq[3] = 2'b11;
    mop(1'b0, 3, 1'b1, 4'h8);

    // R8 / R9: level source 9
    mop(1'b1, 9, 1'b1, 4'hC);
    @(negedge clk); irq_in[9] = 1'b1;
    count_notify(3, cnt, ns);
    chk("R8 rise forward count", 64'(cnt), 64'd1);
    chk("R8 rise notify_src", {60'd0, ns}, 64'd9);
    m_lvl[9] = 1; m_pq[9] = 2'b10;
    mop(1'b0, 9, 1'b1, 4'h8);
    mop(1'b0, 9, 1'b1, 4'h2);
    mop(1'b0, 9, 1'b1, 4'h8);
    mop(1'b1, 9, 1'b1, 4'hF);
    mop(1'b0, 9, 1'b1, 4'h0);
    count_notify(2, cnt, ns);
    chk("R11 single notify after eoi", 64'(cnt), 64'd0);
    @(negedge clk); irq_in[9] = 1'b0;
    count_notify(3, cnt, ns);
    chk("R8 fall quiet", 64'(cnt), 64'd0);
    m_lvl[9] = 0;
    mop(1'b0, 9, 1'b1, 4'h0);
    mop(1'b0, 9, 1'b1, 4'h8);
    mop(1'b1, 9, 1'b1, 4'hE);
    @(negedge clk); irq_in[9] = 1'b1;
    count_notify(3, cnt, ns);
    chk("R8 rise from pending quiet", 64'(cnt), 64'd0);
    m_lvl[9] = 1;
    mop(1'b0, 9, 1'b1, 4'h8);
    @(negedge clk); irq_in[9] = 1'b0;
    count_notify(3, cnt, ns);
    m_lvl[9] = 0;

    // R11 / R12: back-pressure
    mop(1'b1, 0, 1'b1, 4'hC);
    notify_ready = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_store = 1'b1; req_line = la(0, 1'b0, 4'h3);
    @(negedge clk); req_valid = 1'b0;
    chk("R11 notify raised", {63'd0, notify_valid}, 64'd1);
    @(negedge clk);
    chk("R11 notify held", {63'd0, notify_valid}, 64'd1);
    chk("R11 held notify_src", {60'd0, notify_src}, 64'd0);
    chk("R12 ready low while stalled", {63'd0, req_ready}, 64'd0);
    notify_ready = 1'b1;
    @(negedge clk);
    chk("R11 notify released once", {63'd0, notify_valid}, 64'd0);
    chk("R12 ready restored", {63'd0, req_ready}, 64'd1);
    m_pq[0] = 2'b10;
    rsp_ready = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_store = 1'b0; req_line = la(0, 1'b1, 4'h8);
    @(negedge clk); req_valid = 1'b0;
    chk("R12 rsp raised", {63'd0, rsp_valid}, 64'd1);
    @(negedge clk);
    chk("R12 rsp held", {63'd0, rsp_valid}, 64'd1);
    chk("R12 rsp data held", rsp_data, 64'd2);
    chk("R12 ready low on rsp stall", {63'd0, req_ready}, 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 rsp released", {63'd0, rsp_valid}, 64'd0);

    // constrained random software traffic
    for (int n = 0; n < 400; n++) begin
      int  src;
      bit  pg, st;
      logic [3:0] off;
      src = $urandom_range(0, N - 1);
      pg  = ($urandom_range(0, 3) != 0);
      st  = $urandom_range(0, 1);
      off = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) store_eoi_en = ~store_eoi_en;
      mop(st, src, pg, off);
    end
    for (int i = 0; i < N; i++) mop(1'b0, i, 1'b1, 4'h8);

    summary();
    $finish;
  end

endmodule